// File: doc/BRIEF.md
# Parallel Multi-Scheme Value Predictor

This block keeps a small value history for each of several live-in streams. On request it returns three guesses for the next value of one stream, all produced in the same cycle:

- **Last-value guess:** repeats the most recent actual value.
- **Stride guess:** extends the last observed difference.
- **Context guess:** reads a direct-mapped table keyed by the last two values.

Each guess is meant for its own speculative lane. No selector picks among them.

When the real value of a stream becomes known, the commit logic sends it in as an update. The block then does two things:

- It compares the value against the three guesses that were current for that stream and returns a per-lane hit vector. Speculation succeeded if any bit is set.
- It folds the value into the stream's history.

A computation that has several live-in values uses one stream index for each live-in.

Top module: `value_pred_multi`

## Requirements
- R1: After reset every stream has last value 0, no prior update count and an empty context table. `pred_valid_o` and `upd_done_o` are low, and a first request on any stream returns 0 for all three guesses with `pred_ctx_hit_o` low.
- R2: `pred_valid_o` is high exactly in the cycle after `pred_req_i`. The guesses then belong to `pred_stream_i` and reflect the history before any update accepted on the same clock edge.
- R3: The last-value guess equals the most recent value written to that stream by an update.
- R4: The stride guess is last + (last − previous), modulo 2^DATA_W. Until a stream has had two updates, the stride is taken as zero and the guess equals the last value.
- R5: Once a stream has had two updates, the context table is read as follows:
  - The index is the XOR of the low log2(CTX_DEPTH) bits of the last and previous values.
  - The stored tag is the full {previous, last} pair.
  - On a valid tag match, the context guess is the stored next value and `pred_ctx_hit_o` is 1.
- R6: On a context miss, including the case of fewer than two updates, the context guess equals the last value and `pred_ctx_hit_o` is 0.
- R7: An update to a stream that already has two values writes the old {previous, last} pair and the new value into that stream's table entry. A different pair mapping to the same index replaces the entry, so the earlier pair then misses.
- R8: `upd_done_o` is high exactly in the cycle after `upd_valid_i`. In that cycle `hit_o` compares the update value with the pre-update guesses of `upd_stream_i`:
  - bit 0 is the last-value guess;
  - bit 1 is the stride guess;
  - bit 2 is the context guess, and is set only when the context lookup hit.
- R9: `any_hit_o` is high when at least one bit of `hit_o` is high.
- R10: An update to one stream leaves the guesses of every other stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_req_i | input | 1 | Prediction request |
| pred_stream_i | input | SID_W | Stream to predict |
| upd_valid_i | input | 1 | Actual value update |
| upd_stream_i | input | SID_W | Stream being updated |
| upd_value_i | input | DATA_W | Actual value |
| pred_valid_o | output | 1 | Predictions valid |
| pred_last_o | output | DATA_W | Last-value guess |
| pred_stride_o | output | DATA_W | Stride guess |
| pred_ctx_o | output | DATA_W | Context guess |
| pred_ctx_hit_o | output | 1 | Context lookup hit |
| upd_done_o | output | 1 | Update result valid |
| hit_o | output | 3 | Per-lane match: 0 last, 1 stride, 2 context |
| any_hit_o | output | 1 | At least one lane matched |

## Verification
A corrupted history register shows up on the next request to that stream, as a wrong last-value or stride guess one cycle after the request. It also shows up on the next update, as a wrong hit bit. A bad table write stays hidden until the same value pair recurs: only then does the context guess or its hit flag differ. The bench therefore replays repeating sequences and aliasing pairs. Mixing updates and requests across streams exposes any write that lands in the wrong stream on that stream's next request.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int LANE_LAST   = 0;
  localparam int LANE_STRIDE = 1;
  localparam int LANE_CTX    = 2;
  localparam int N_LANES     = 3;
endpackage

// File: rtl/vp_ctx_table.sv
module vp_ctx_table #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              valid_q [DEPTH];
  logic [TAG_W-1:0]  tag_q   [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
      data_q[wr_idx_i]  <= wr_data_i;
    end
  end

  assign rd_hit_o  = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_data_o = data_q[rd_idx_i];

  // R5/R7: a freshly written pair is found again with its next value
  a_r7_write_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && rd_idx_i == $past(wr_idx_i) && rd_tag_i == $past(wr_tag_i))
      |-> (rd_hit_o && rd_data_o == $past(wr_data_i)));
endmodule

// File: rtl/vp_stream.sv
module vp_stream #(
  parameter int DATA_W    = 16,
  parameter int CTX_DEPTH = 16,
  localparam int IDX_W    = $clog2(CTX_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [DATA_W-1:0] upd_value_i,
  output logic [DATA_W-1:0] last_o,
  output logic [DATA_W-1:0] stride_o,
  output logic [DATA_W-1:0] ctx_o,
  output logic              ctx_hit_o
);
  logic [DATA_W-1:0]   last_q, prev_q;
  logic [1:0]          cnt_q;
  logic                have_pair;
  logic [IDX_W-1:0]    ctx_idx;
  logic [2*DATA_W-1:0] ctx_tag;
  logic                tbl_hit;
  logic [DATA_W-1:0]   tbl_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en_i) begin
      prev_q <= last_q;
      last_q <= upd_value_i;
      if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
    end
  end

  assign have_pair = (cnt_q == 2'd2);
  assign ctx_idx   = last_q[IDX_W-1:0] ^ prev_q[IDX_W-1:0];
  assign ctx_tag   = {prev_q, last_q};

  vp_ctx_table #(.DATA_W(DATA_W), .DEPTH(CTX_DEPTH)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (upd_en_i && have_pair),
    .wr_idx_i  (ctx_idx),
    .wr_tag_i  (ctx_tag),
    .wr_data_i (upd_value_i),
    .rd_idx_i  (ctx_idx),
    .rd_tag_i  (ctx_tag),
    .rd_hit_o  (tbl_hit),
    .rd_data_o (tbl_data)
  );

  assign last_o    = last_q;
  assign stride_o  = have_pair ? (last_q + (last_q - prev_q)) : last_q;
  assign ctx_hit_o = have_pair && tbl_hit;
  assign ctx_o     = ctx_hit_o ? tbl_data : last_q;

  // R3: last value tracks the most recent update
  a_r3_last_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_en_i) |-> (last_o == $past(upd_value_i)));
endmodule

// File: rtl/value_pred_multi.sv
module value_pred_multi
  import vp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int N_STREAMS = 4,
  parameter int CTX_DEPTH = 16,
  localparam int SID_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pred_req_i,
  input  logic [SID_W-1:0]   pred_stream_i,
  input  logic               upd_valid_i,
  input  logic [SID_W-1:0]   upd_stream_i,
  input  logic [DATA_W-1:0]  upd_value_i,
  output logic               pred_valid_o,
  output logic [DATA_W-1:0]  pred_last_o,
  output logic [DATA_W-1:0]  pred_stride_o,
  output logic [DATA_W-1:0]  pred_ctx_o,
  output logic               pred_ctx_hit_o,
  output logic               upd_done_o,
  output logic [N_LANES-1:0] hit_o,
  output logic               any_hit_o
);
  logic [DATA_W-1:0] last_w   [N_STREAMS];
  logic [DATA_W-1:0] stride_w [N_STREAMS];
  logic [DATA_W-1:0] ctx_w    [N_STREAMS];
  logic              chit_w   [N_STREAMS];

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    vp_stream #(.DATA_W(DATA_W), .CTX_DEPTH(CTX_DEPTH)) u_stream (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_en_i    (upd_valid_i && (upd_stream_i == SID_W'(s))),
      .upd_value_i (upd_value_i),
      .last_o      (last_w[s]),
      .stride_o    (stride_w[s]),
      .ctx_o       (ctx_w[s]),
      .ctx_hit_o   (chit_w[s])
    );
  end

  logic [N_LANES-1:0] hit_d;
  always_comb begin
    hit_d = '0;
    hit_d[LANE_LAST]   = (upd_value_i == last_w[upd_stream_i]);
    hit_d[LANE_STRIDE] = (upd_value_i == stride_w[upd_stream_i]);
    hit_d[LANE_CTX]    = chit_w[upd_stream_i] && (upd_value_i == ctx_w[upd_stream_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o   <= 1'b0;
      pred_last_o    <= '0;
      pred_stride_o  <= '0;
      pred_ctx_o     <= '0;
      pred_ctx_hit_o <= 1'b0;
      upd_done_o     <= 1'b0;
      hit_o          <= '0;
      any_hit_o      <= 1'b0;
    end else begin
      pred_valid_o <= pred_req_i;
      if (pred_req_i) begin
        pred_last_o    <= last_w[pred_stream_i];
        pred_stride_o  <= stride_w[pred_stream_i];
        pred_ctx_o     <= ctx_w[pred_stream_i];
        pred_ctx_hit_o <= chit_w[pred_stream_i];
      end
      upd_done_o <= upd_valid_i;
      hit_o      <= upd_valid_i ? hit_d : '0;
      any_hit_o  <= upd_valid_i && (|hit_d);
    end
  end

  a_r2_pred_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o == $past(pred_req_i));
  a_r8_upd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o == $past(upd_valid_i));
  a_r6_miss_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o && !pred_ctx_hit_o) |-> (pred_ctx_o == pred_last_o));
  a_r8_idle_no_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_done_o |-> (hit_o == '0 && !any_hit_o));
endmodule

// File: tb/test_value_pred_multi.sv
`timescale 1ns/1ps
module test_value_pred_multi;
  localparam int DW = 16, NS = 4, CD = 16, SW = 2, IW = 4;

  logic clk = 0, rst_ni = 0;
  logic pred_req_i = 0, upd_valid_i = 0;
  logic [SW-1:0] pred_stream_i = 0, upd_stream_i = 0;
  logic [DW-1:0] upd_value_i = 0;
  logic pred_valid_o, pred_ctx_hit_o, upd_done_o, any_hit_o;
  logic [DW-1:0] pred_last_o, pred_stride_o, pred_ctx_o;
  logic [2:0] hit_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  value_pred_multi #(.DATA_W(DW), .N_STREAMS(NS), .CTX_DEPTH(CD)) i_value_pred_multi (
    .clk_i(clk), .rst_ni(rst_ni),
    .pred_req_i(pred_req_i), .pred_stream_i(pred_stream_i),
    .upd_valid_i(upd_valid_i), .upd_stream_i(upd_stream_i), .upd_value_i(upd_value_i),
    .pred_valid_o(pred_valid_o), .pred_last_o(pred_last_o), .pred_stride_o(pred_stride_o),
    .pred_ctx_o(pred_ctx_o), .pred_ctx_hit_o(pred_ctx_hit_o),
    .upd_done_o(upd_done_o), .hit_o(hit_o), .any_hit_o(any_hit_o)
  );

  // behavioural reference
  logic [DW-1:0] m_last [NS];
  logic [DW-1:0] m_prev [NS];
  int            m_cnt  [NS];
  bit            m_tv   [NS][CD];
  logic [2*DW-1:0] m_tag [NS][CD];
  logic [DW-1:0] m_nxt  [NS][CD];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_pred(input int s, output logic [DW-1:0] l, output logic [DW-1:0] st,
                            output logic [DW-1:0] c, output bit h);
    int idx;
    l  = m_last[s];
    st = (m_cnt[s] >= 2) ? DW'(m_last[s] + (m_last[s] - m_prev[s])) : m_last[s];
    idx = int'(m_last[s][IW-1:0] ^ m_prev[s][IW-1:0]);
    h  = (m_cnt[s] >= 2) && m_tv[s][idx] && (m_tag[s][idx] == {m_prev[s], m_last[s]});
    c  = h ? m_nxt[s][idx] : m_last[s];
  endtask

  task automatic model_upd(input int s, input logic [DW-1:0] v);
    int idx;
    if (m_cnt[s] >= 2) begin
      idx = int'(m_last[s][IW-1:0] ^ m_prev[s][IW-1:0]);
      m_tv[s][idx]  = 1;
      m_tag[s][idx] = {m_prev[s], m_last[s]};
      m_nxt[s][idx] = v;
    end
    m_prev[s] = m_last[s];
    m_last[s] = v;
    if (m_cnt[s] < 2) m_cnt[s]++;
  endtask

  // one cycle: drive at negedge, check registered outputs at the next negedge
  task automatic step(input bit pr, input int ps, input bit uv, input int us, input logic [DW-1:0] val);
    logic [DW-1:0] pl, pst, pc, ul, ust, uc;
    bit ph, uh;
    logic [2:0] eh;
    pred_req_i = pr; pred_stream_i = SW'(ps);
    upd_valid_i = uv; upd_stream_i = SW'(us); upd_value_i = val;
    model_pred(ps, pl, pst, pc, ph);
    model_pred(us, ul, ust, uc, uh);
    eh = {uh && (val == uc), val == ust, val == ul};
    if (uv) model_upd(us, val);
    @(negedge clk);
    pred_req_i = 0; upd_valid_i = 0;
    chk(pred_valid_o == pr, "R2", "pred_valid", pred_valid_o, pr);
    if (pr) begin
      chk(pred_last_o == pl, "R3", "last guess", pred_last_o, pl);
      chk(pred_stride_o == pst, "R4", "stride guess", pred_stride_o, pst);
      chk(pred_ctx_hit_o == ph, ph ? "R5" : "R6", "ctx hit", pred_ctx_hit_o, ph);
      chk(pred_ctx_o == pc, ph ? "R5" : "R6", "ctx guess", pred_ctx_o, pc);
    end
    chk(upd_done_o == uv, "R8", "upd_done", upd_done_o, uv);
    if (uv) begin
      chk(hit_o == eh, "R8", "hit vector", hit_o, eh);
      chk(any_hit_o == (|eh), "R9", "any hit", any_hit_o, |eh);
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] saved;
    for (int s = 0; s < NS; s++) begin
      m_last[s] = 0; m_prev[s] = 0; m_cnt[s] = 0;
      for (int i = 0; i < CD; i++) begin m_tv[s][i] = 0; m_tag[s][i] = 0; m_nxt[s][i] = 0; end
    end
    repeat (3) @(negedge clk);
    chk(pred_valid_o == 0 && upd_done_o == 0, "R1", "reset outputs", {pred_valid_o, upd_done_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      step(1, s, 0, 0, 0);
      chk(pred_last_o == 0 && pred_stride_o == 0 && pred_ctx_o == 0 && !pred_ctx_hit_o,
          "R1", "reset guesses", {pred_last_o, pred_ctx_hit_o}, 0);
    end
    // stride stream, predict and update same stream same cycle
    for (int k = 0; k < 6; k++) step(1, 1, 1, 1, DW'(10 + 3 * k));
    step(1, 1, 0, 0, 0);
    chk(pred_stride_o == DW'(28), "R4", "stride after ramp", pred_stride_o, 28);
    // wraparound stride
    step(0, 0, 1, 1, 16'hFFFE);
    step(1, 1, 1, 1, 16'h0003);
    // repeating pattern for context hits
    for (int r = 0; r < 4; r++) begin
      step(1, 2, 1, 2, 16'd5);
      step(1, 2, 1, 2, 16'd9);
      step(1, 2, 1, 2, 16'd2);
    end
    step(1, 2, 0, 0, 0);
    chk(pred_ctx_hit_o == 1 && pred_ctx_o == 5, "R5", "pattern ctx", pred_ctx_o, 5);
    // independence
    saved = m_last[2];
    for (int k = 0; k < 5; k++) step(0, 0, 1, 0, DW'(100 * k + 1));
    step(1, 2, 0, 0, 0);
    chk(pred_last_o == saved, "R10", "other stream intact", pred_last_o, saved);
    // aliasing on stream 3: (1,2) then (0x11,0x12) share index 3
    step(0, 0, 1, 3, 16'd1);
    step(0, 0, 1, 3, 16'd2);
    step(1, 3, 1, 3, 16'd7);
    step(0, 0, 1, 3, 16'h11);
    step(0, 0, 1, 3, 16'h12);
    step(1, 3, 1, 3, 16'd9);
    step(0, 0, 1, 3, 16'd1);
    step(0, 0, 1, 3, 16'd2);
    step(1, 3, 0, 0, 0);
    chk(pred_ctx_hit_o == 0 && pred_ctx_o == 2, "R7", "aliased entry replaced", pred_ctx_o, 2);
    // random mix with small values for frequent context reuse
    for (int k = 0; k < 600; k++)
      step($urandom_range(0, 1), $urandom_range(0, NS - 1), $urandom_range(0, 1),
           $urandom_range(0, NS - 1), DW'($urandom_range(0, 5)));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule